// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block takes a configuration stream one bit at a time, qualified by a bit enable, and parses it. The stream starts with a header: a padding run of ones, a four-bit sync code, a 24-bit total length and a separator run of ones. A fixed number of equal-sized frames follows. Each frame is a zero start bit, a data field and a four-bit trailer. The stream closes with an eight-bit closing code and optional further ones. The data field of each good frame appears on a parallel output with a one-cycle strobe.

A free-running counter counts every accepted bit from the last program pulse or reset, leading ones included. The load is complete when that count equals the captured length, and only a well-formed closing code may coincide with that point. Any framing fault freezes the loader and pulls an active-low status output low. It stays there until the program input or reset.

The controller has the states LEAD (skip padding ones), SYNC (rest of the sync code), LENGTH (shift in the count), SEP (separator ones), FRAME (frame body), GAP (start bit of the next frame), CLOSE (closing code), TAIL (extra ones), DONE and FAULT. Its transitions are:
- LEAD→SYNC on the first zero.
- SYNC→LENGTH after the code matches.
- LENGTH→SEP after 24 bits.
- SEP→FRAME on a zero that follows at least four ones.
- FRAME→GAP after a good frame that is not the last.
- FRAME→CLOSE after the last good frame.
- GAP→FRAME on a zero.
- CLOSE→DONE or CLOSE→TAIL after the eighth closing bit, depending on whether the length has been reached.
- TAIL→DONE when the length is reached.
- Any state to FAULT on a fault.
- Program returns every state to LEAD.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset or a program pulse, cfg_ok_n is 1, load_done is 0, field_vld is 0 and field_data is 0.
- R2: Any number of leading ones is ignored. The first zero must begin the sync code 0010, received left bit first. Any mismatch is a fault.
- R3: The 24 bits after the sync code form the length, most significant bit first. It counts every accepted bit since program or reset. load_done pulses for exactly one cycle, in the cycle after the bit that brings the count to the length, when that bit completes a valid stream.
- R4: After the length comes a separator of ones. A zero after fewer than four separator ones is a fault. A zero after four or more ones is the start bit of the first frame.
- R5: Each frame after the first must begin with a zero start bit. The last four bits of every frame must be 0110, received left bit first. Anything else is a fault.
- R6: The data field of a good frame is FRAME_BITS-5 bits wide. Its first received bit lands in the most significant position of field_data. field_data is presented with a one-cycle field_vld in the cycle after the frame's last trailer bit, and it holds until the next strobe or program.
- R7: After the last frame the stream must carry the closing code 01111111, then only ones. A zero in the tail is a fault. A count reaching the length at any point after the length field, other than at the last closing bit or in the tail, is a fault.
- R8: A fault drives cfg_ok_n low in the cycle after the faulty bit. It stays low with no further field_vld or load_done until program or reset.
- R9: After load_done, further bits, zeros included, cause no strobe, no done and no fault until program.
- R10: Program takes priority over a bit in the same cycle and restarts parsing, so a complete new stream then loads.
- R11: While bit_en is low, din has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog | input | 1 | Synchronous restart of loading |
| bit_en | input | 1 | Qualifies din for this cycle |
| din | input | 1 | Serial stream bit |
| field_data | output | FRAME_BITS-5 | Data field of the last good frame |
| field_vld | output | 1 | One-cycle strobe for field_data |
| load_done | output | 1 | One-cycle completion pulse |
| cfg_ok_n | output | 1 | Low after a fault, until program or reset |

## Verification
The bench builds the loader with FRAME_BITS=12 and NUM_FRAMES=3. That gives a 7-bit field and streams of about ninety bits, so many complete streams fit in a short run. Three frames make both frame-to-frame start bits and the last-frame handoff to the closing code reachable. The odd field width lets asymmetric patterns expose any bit reversal or offset in the captured field. Streams vary the padding and separator lengths, add tail ones, and interleave idle cycles. They also inject one fault at each parsing stage, plus a length that runs out mid-frame.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

    typedef enum logic [3:0] {
        S_LEAD,
        S_SYNC,
        S_LENGTH,
        S_SEP,
        S_FRAME,
        S_GAP,
        S_CLOSE,
        S_TAIL,
        S_DONE,
        S_FAULT
    } ld_state_t;

    localparam int LEN_BITS   = 24;
    localparam int SEP_MIN    = 4;
    localparam int CLOSE_BITS = 8;
    localparam logic [3:0] TRAILER_CODE = 4'b0110;

endpackage

// File: rtl/cfg_ld_shift.sv
module cfg_ld_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= {q[W-2:0], din};
        end
    end

endmodule

// File: rtl/cfg_ld_bitcnt.sv
module cfg_ld_bitcnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] len_in,
    output logic         hit
);

    logic [W-1:0] cnt;
    logic [W-1:0] limit;
    logic [W-1:0] cnt_nx;

    assign cnt_nx = cnt + {{(W-1){1'b0}}, 1'b1};
    assign hit    = (cnt_nx == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            limit <= '0;
        end else if (clr) begin
            cnt   <= '0;
            limit <= '0;
        end else begin
            if (adv) begin
                cnt <= cnt_nx;
            end
            if (load) begin
                limit <= len_in;
            end
        end
    end

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfg_ld_pkg::*;
#(
    parameter int FRAME_BITS = 12,
    parameter int NUM_FRAMES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prog,
    input  logic                  bit_en,
    input  logic                  din,
    output logic [FRAME_BITS-6:0] field_data,
    output logic                  field_vld,
    output logic                  load_done,
    output logic                  cfg_ok_n
);

    localparam int DW   = FRAME_BITS - 5;
    localparam int SH_W = (FRAME_BITS > LEN_BITS) ? FRAME_BITS : LEN_BITS;
    localparam int FC_W = $clog2(SH_W + 1);
    localparam int NF_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

    ld_state_t       state, nxt;
    logic [FC_W-1:0] fcnt, fcnt_nx;
    logic [NF_W-1:0] frm, frm_nx;
    logic            acc, shift_en, len_ld, hit;
    logic            fault_ev, vld_ev, done_ev;
    logic [SH_W-1:0] sh;

    assign acc = bit_en && !prog && (state != S_DONE) && (state != S_FAULT);

    cfg_ld_shift #(.W(SH_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (prog),
        .en   (shift_en),
        .din  (din),
        .q    (sh)
    );

    cfg_ld_bitcnt #(.W(LEN_BITS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (prog),
        .adv   (acc),
        .load  (len_ld),
        .len_in({sh[LEN_BITS-2:0], din}),
        .hit   (hit)
    );

    // next state and events
    always_comb begin
        nxt      = state;
        fcnt_nx  = fcnt;
        frm_nx   = frm;
        shift_en = 1'b0;
        len_ld   = 1'b0;
        fault_ev = 1'b0;
        vld_ev   = 1'b0;
        done_ev  = 1'b0;
        if (acc) begin
            unique case (state)
                S_LEAD: begin
                    if (!din) begin
                        nxt     = S_SYNC;
                        fcnt_nx = FC_W'(1);
                    end
                end
                S_SYNC: begin
                    if (din != (fcnt == FC_W'(2))) begin
                        fault_ev = 1'b1;
                    end else if (fcnt == FC_W'(3)) begin
                        nxt     = S_LENGTH;
                        fcnt_nx = '0;
                    end else begin
                        fcnt_nx = fcnt + FC_W'(1);
                    end
                end
                S_LENGTH: begin
                    shift_en = 1'b1;
                    if (fcnt == FC_W'(LEN_BITS - 1)) begin
                        len_ld  = 1'b1;
                        nxt     = S_SEP;
                        fcnt_nx = '0;
                    end else begin
                        fcnt_nx = fcnt + FC_W'(1);
                    end
                end
                S_SEP: begin
                    if (hit) begin
                        fault_ev = 1'b1;
                    end else if (din) begin
                        if (fcnt < FC_W'(SEP_MIN)) fcnt_nx = fcnt + FC_W'(1);
                    end else if (fcnt >= FC_W'(SEP_MIN)) begin
                        nxt     = S_FRAME;
                        fcnt_nx = FC_W'(1);
                    end else begin
                        fault_ev = 1'b1;
                    end
                end
                S_GAP: begin
                    if (hit || din) begin
                        fault_ev = 1'b1;
                    end else begin
                        nxt     = S_FRAME;
                        fcnt_nx = FC_W'(1);
                    end
                end
                S_FRAME: begin
                    shift_en = 1'b1;
                    if (hit) begin
                        fault_ev = 1'b1;
                    end else if (fcnt == FC_W'(FRAME_BITS - 1)) begin
                        if ({sh[2:0], din} != TRAILER_CODE) begin
                            fault_ev = 1'b1;
                        end else begin
                            vld_ev  = 1'b1;
                            fcnt_nx = '0;
                            if (frm == NF_W'(NUM_FRAMES - 1)) begin
                                nxt    = S_CLOSE;
                                frm_nx = '0;
                            end else begin
                                nxt    = S_GAP;
                                frm_nx = frm + NF_W'(1);
                            end
                        end
                    end else begin
                        fcnt_nx = fcnt + FC_W'(1);
                    end
                end
                S_CLOSE: begin
                    if (din != (fcnt != '0)) begin
                        fault_ev = 1'b1;
                    end else if (fcnt == FC_W'(CLOSE_BITS - 1)) begin
                        if (hit) begin
                            done_ev = 1'b1;
                            nxt     = S_DONE;
                        end else begin
                            nxt = S_TAIL;
                        end
                    end else if (hit) begin
                        fault_ev = 1'b1;
                    end else begin
                        fcnt_nx = fcnt + FC_W'(1);
                    end
                end
                S_TAIL: begin
                    if (!din) begin
                        fault_ev = 1'b1;
                    end else if (hit) begin
                        done_ev = 1'b1;
                        nxt     = S_DONE;
                    end
                end
                S_DONE, S_FAULT: begin
                end
                default: begin
                end
            endcase
        end
        if (fault_ev) nxt = S_FAULT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_LEAD;
            fcnt  <= '0;
            frm   <= '0;
        end else if (prog) begin
            state <= S_LEAD;
            fcnt  <= '0;
            frm   <= '0;
        end else begin
            state <= nxt;
            fcnt  <= fcnt_nx;
            frm   <= frm_nx;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_data <= '0;
            field_vld  <= 1'b0;
            load_done  <= 1'b0;
            cfg_ok_n   <= 1'b1;
        end else if (prog) begin
            field_data <= '0;
            field_vld  <= 1'b0;
            load_done  <= 1'b0;
            cfg_ok_n   <= 1'b1;
        end else begin
            field_vld <= vld_ev;
            load_done <= done_ev;
            if (fault_ev) cfg_ok_n <= 1'b0;
            if (vld_ev) field_data <= sh[DW+2:3];
        end
    end

endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk #(
    parameter int FRAME_BITS = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  prog,
    input logic                  bit_en,
    input logic [FRAME_BITS-6:0] field_data,
    input logic                  field_vld,
    input logic                  load_done,
    input logic                  cfg_ok_n
);

    // fault is sticky until program
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ok_n && !prog) |=> !cfg_ok_n);

    // no strobes while faulted
    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok_n |-> (!field_vld && !load_done));

    // completion is a single-cycle pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);

    // after completion nothing else happens
    p_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> cfg_ok_n);

    // field strobe is a single-cycle pulse
    p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        field_vld |=> !field_vld);

    // field holds between strobes
    p_field_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !prog |=> (field_vld || $stable(field_data)));

    // idle cycles change nothing
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !prog) |=> (!field_vld && !load_done && $stable(cfg_ok_n)));

    // program restores the initial outputs
    p_prog_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (cfg_ok_n && !load_done && !field_vld && field_data == '0));

endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog      (prog),
    .bit_en    (bit_en),
    .field_data(field_data),
    .field_vld (field_vld),
    .load_done (load_done),
    .cfg_ok_n  (cfg_ok_n)
);

// File: tb/tb_cfg_stream_loader.sv
module tb_cfg_stream_loader;

    localparam int FB = 12;
    localparam int NF = 3;
    localparam int DW = FB - 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog = 1'b0;
    logic          bit_en = 1'b0;
    logic          din = 1'b0;
    logic [DW-1:0] field_data;
    logic          field_vld, load_done, cfg_ok_n;

    int checks = 0;
    int errors = 0;
    string req = "R1";

    bit mq[$];
    bit stim[$];
    bit frozen = 0;
    int prev_nfr = 0;
    logic e_init = 1'b1, e_done = 1'b0, e_vld = 1'b0;
    logic [DW-1:0] e_data = '0;
    int done_seen = 0;
    int vld_seen = 0;

    always #10 clk = ~clk;

    cfg_stream_loader #(.FRAME_BITS(FB), .NUM_FRAMES(NF)) dut (
        .clk(clk), .rst_n(rst_n), .prog(prog), .bit_en(bit_en), .din(din),
        .field_data(field_data), .field_vld(field_vld),
        .load_done(load_done), .cfg_ok_n(cfg_ok_n)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model: re-parse all bits received since program
    function automatic void parse(output int st, output int nfr, output logic [DW-1:0] last);
        int n = mq.size();
        int i = 0;
        int len = 0;
        int ones = 0;
        logic [DW-1:0] d = '0;
        logic [3:0] ck = '0;
        st = 0; nfr = 0; last = '0;
        while (i < n && mq[i]) i++;
        for (int k = 0; k < 4; k++) begin
            if (i >= n) return;
            if (mq[i] != (k == 2)) begin st = 1; return; end
            i++;
        end
        for (int k = 0; k < 24; k++) begin
            if (i >= n) return;
            len = len * 2 + int'(mq[i]);
            i++;
        end
        while (1) begin
            if (i >= n) return;
            if (i + 1 == len) begin st = 1; return; end
            if (!mq[i]) break;
            ones++;
            i++;
        end
        if (ones < 4) begin st = 1; return; end
        i++;
        for (int f = 0; f < NF; f++) begin
            if (f > 0) begin
                if (i >= n) return;
                if (i + 1 == len || mq[i]) begin st = 1; return; end
                i++;
            end
            for (int k = 0; k < DW; k++) begin
                if (i >= n) return;
                if (i + 1 == len) begin st = 1; return; end
                d = {d[DW-2:0], mq[i]};
                i++;
            end
            for (int k = 0; k < 4; k++) begin
                if (i >= n) return;
                if (i + 1 == len) begin st = 1; return; end
                ck = {ck[2:0], mq[i]};
                i++;
            end
            if (ck != 4'b0110) begin st = 1; return; end
            nfr++;
            last = d;
        end
        for (int k = 0; k < 8; k++) begin
            if (i >= n) return;
            if (mq[i] != (k != 0)) begin st = 1; return; end
            if (i + 1 == len) begin
                if (k == 7) st = 2; else st = 1;
                return;
            end
            i++;
        end
        while (1) begin
            if (i >= n) return;
            if (!mq[i]) begin st = 1; return; end
            if (i + 1 == len) begin st = 2; return; end
            i++;
        end
    endfunction

    task automatic step(input logic en, input logic b, input logic pg);
        int st, nfr;
        logic [DW-1:0] last;
        bit_en = en; din = b; prog = pg;
        if (pg) begin
            mq.delete(); frozen = 0; prev_nfr = 0;
            e_init = 1'b1; e_done = 1'b0; e_vld = 1'b0; e_data = '0;
        end else if (en && !frozen) begin
            mq.push_back(b);
            parse(st, nfr, last);
            e_vld = (nfr > prev_nfr);
            if (e_vld) e_data = last;
            e_done = (st == 2);
            e_init = (st != 1);
            frozen = (st != 0);
            prev_nfr = nfr;
        end else begin
            e_vld = 1'b0; e_done = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        if (load_done) done_seen++;
        if (field_vld) vld_seen++;
        check("cfg_ok_n", 32'(cfg_ok_n), 32'(e_init));
        check("load_done", 32'(load_done), 32'(e_done));
        check("field_vld", 32'(field_vld), 32'(e_vld));
        check("field_data", 32'(field_data), 32'(e_data));
    endtask

    task automatic push_ones(input int n);
        for (int k = 0; k < n; k++) stim.push_back(1'b1);
    endtask

    task automatic push_val(input logic [31:0] v, input int w);
        for (int k = w - 1; k >= 0; k--) stim.push_back(v[k]);
    endtask

    // full stream builder; faults injected through the arguments
    task automatic build(input int lead, input logic [3:0] sync, input int len_adj, input int sep,
                         input logic [DW-1:0] d0, input logic [DW-1:0] d1, input logic [DW-1:0] d2,
                         input logic [3:0] trl1, input logic st1, input logic [7:0] close, input int tail);
        int len;
        logic [DW-1:0] dv[3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        len = lead + 4 + 24 + sep + NF * FB + 8 + tail + len_adj;
        stim.delete();
        push_ones(lead);
        push_val(32'(sync), 4);
        push_val(32'(len), 24);
        push_ones(sep);
        for (int f = 0; f < NF; f++) begin
            stim.push_back((f == 1) ? st1 : 1'b0);
            push_val(32'(dv[f]), DW);
            push_val(32'((f == 1) ? trl1 : 4'b0110), 4);
        end
        push_val(32'(close), 8);
        push_ones(tail);
    endtask

    task automatic send(input int gap);
        for (int k = 0; k < stim.size(); k++) begin
            step(1'b1, stim[k], 1'b0);
            if (gap > 0 && (k % gap) == gap - 1) step(1'b0, ~stim[k], 1'b0);
        end
    endtask

    task automatic reprogram();
        step(1'b0, 1'b0, 1'b1);
        done_seen = 0;
        vld_seen = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state after reset
        req = "R1";
        step(1'b0, 1'b0, 1'b0);

        // R3, R5, R6: clean stream, minimum padding
        req = "R3/R5/R6";
        build(8, 4'b0010, 0, 4, 7'h55, 7'h2A, 7'h13, 4'b0110, 1'b0, 8'h7F, 0);
        send(0);
        req = "R3"; check("done count", 32'(done_seen), 32'd1);
        req = "R6"; check("strobe count", 32'(vld_seen), 32'd3);

        // R9: bits after completion are ignored
        req = "R9";
        for (int k = 0; k < 12; k++) step(1'b1, k[0], 1'b0);
        check("done after tail", 32'(done_seen), 32'd1);

        // R2, R4, R7, R11: long padding and separator, tail ones, idle gaps
        req = "R1";
        reprogram();
        req = "R2/R4/R7/R11";
        build(13, 4'b0010, 0, 7, 7'h40, 7'h01, 7'h7E, 4'b0110, 1'b0, 8'h7F, 3);
        send(3);
        req = "R7"; check("done count", 32'(done_seen), 32'd1);

        // R2, R8: bad sync code, then more bits
        reprogram();
        req = "R2/R8";
        build(9, 4'b0011, 0, 4, 7'h11, 7'h22, 7'h33, 4'b0110, 1'b0, 8'h7F, 0);
        send(0);
        req = "R8"; check("fault held", 32'(cfg_ok_n), 32'd0);
        check("no strobe", 32'(vld_seen), 32'd0);

        // R4: only three separator ones
        reprogram();
        req = "R4";
        build(8, 4'b0010, 0, 3, 7'h11, 7'h22, 7'h33, 4'b0110, 1'b0, 8'h7F, 0);
        send(0);
        check("fault", 32'(cfg_ok_n), 32'd0);

        // R5: bad trailer on the second frame
        reprogram();
        req = "R5";
        build(8, 4'b0010, 0, 4, 7'h6C, 7'h22, 7'h33, 4'b0111, 1'b0, 8'h7F, 0);
        send(0);
        check("strobe count", 32'(vld_seen), 32'd1);

        // R5: bad start bit on the second frame
        reprogram();
        req = "R5";
        build(8, 4'b0010, 0, 4, 7'h05, 7'h22, 7'h33, 4'b0110, 1'b1, 8'h7F, 0);
        send(0);
        check("fault", 32'(cfg_ok_n), 32'd0);

        // R7: bad closing code
        reprogram();
        req = "R7";
        build(8, 4'b0010, 0, 4, 7'h05, 7'h22, 7'h33, 4'b0110, 1'b0, 8'h3F, 0);
        send(0);
        check("no done", 32'(done_seen), 32'd0);

        // R7: length runs out inside a frame
        reprogram();
        req = "R7/R3";
        build(8, 4'b0010, -20, 4, 7'h05, 7'h22, 7'h33, 4'b0110, 1'b0, 8'h7F, 0);
        send(0);
        check("no done", 32'(done_seen), 32'd0);

        // R7: zero in the tail
        reprogram();
        req = "R7";
        build(8, 4'b0010, 0, 4, 7'h05, 7'h22, 7'h33, 4'b0110, 1'b0, 8'h7F, 4);
        stim[stim.size() - 2] = 1'b0;
        send(0);
        check("fault", 32'(cfg_ok_n), 32'd0);

        // R10: program mid-stream, bit in same cycle ignored, new stream loads
        reprogram();
        req = "R10";
        build(8, 4'b0010, 0, 4, 7'h05, 7'h22, 7'h33, 4'b0110, 1'b0, 8'h7F, 0);
        for (int k = 0; k < 50; k++) step(1'b1, stim[k], 1'b0);
        step(1'b1, 1'b0, 1'b1);
        done_seen = 0; vld_seen = 0;
        build(10, 4'b0010, 0, 5, 7'h3C, 7'h47, 7'h18, 4'b0110, 1'b0, 8'h7F, 1);
        send(0);
        check("done count", 32'(done_seen), 32'd1);
        check("strobe count", 32'(vld_seen), 32'd3);
        check("last field", 32'(field_data), 32'h18);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule